// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external asynchronous static RAM with a 19-bit address, an 8-bit data bus, two chip enables (one active-low, one active-high), an active-low output enable and an active-low write enable. The host makes one single-word request at a time on a valid/ready port that carries an address, write data and a direction flag. The controller then runs the matching pin sequence on the RAM. A read returns its byte with a one-cycle valid pulse.

All RAM timing minimums are parameters counted in clock cycles. Each default is the nanosecond figure of the faster speed grade divided by a 10 ns clock and rounded up. A write keeps write-enable low long enough to cover the pulse width, the address-valid-to-end time and the data setup. The enable, the address and the data then stay in place for a hold period. A read keeps output-enable low for the full access time and captures the bus on the closing edge. After each read, a standby gap lets the RAM release the shared bus before the controller can drive it again. With no request pending, the RAM is deselected and write-enable and output-enable stay high.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, reqReady is 1, rdValid is 0, memCeN is 1, memCe is 0, memWeN is 1, memOeN is 1 and memDqOe is 0.
- R2: Whenever reqReady is 1 the RAM is in standby: memCeN=1, memCe=0, memWeN=1, memOeN=1 and memDqOe=0.
- R3: A write request (reqWrite=1) holds memWeN low for exactly WR_PULSE_CYC cycles (default 6) with the chip selected. During that time memOeN is 1 and memAddr and memDqOut stay constant.
- R4: After memWeN rises, the chip stays selected with memAddr and memDqOut unchanged for WR_HOLD_CYC cycles (default 1). Then the controller returns to standby.
- R5: memDqOe is 1 only while memWeN is low or during the write hold cycles, so a write drives the bus for WR_PULSE_CYC+WR_HOLD_CYC cycles and a read never drives it.
- R6: A read request (reqWrite=0) holds memOeN low and memWeN high for exactly RD_ACC_CYC cycles (default 7), with the chip selected and memAddr constant.
- R7: The data bus is captured on the edge that ends the read access. rdData then holds that byte and rdValid is 1 for exactly one cycle, in the cycle after memOeN rises.
- R8: After every read, the RAM stays deselected for TURN_CYC cycles (default 3) before reqReady returns. The bus is therefore not driven for at least the output-disable time after output-enable rises.
- R9: reqReady is 0 from the cycle after a request is accepted until the sequence ends. A request is accepted only on a clock edge where reqValid and reqReady are both 1.
- R10: A read from an address returns the byte most recently written there, for any 19-bit address including 0 and 0x7FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Request word address |
| reqWdata | input | 8 | Write data |
| rdValid | output | 1 | One-cycle pulse: rdData holds read result |
| rdData | output | 8 | Captured read data |
| memAddr | output | 19 | RAM address pins |
| memCeN | output | 1 | RAM chip enable, active low |
| memCe | output | 1 | RAM chip enable, active high |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memDqOut | output | 8 | Data driven toward the RAM |
| memDqOe | output | 1 | Drive enable for memDqOut at the pad |
| memDqIn | input | 8 | Data returned from the RAM pins |

## Verification
The checker watches several properties on every cycle. It checks that the idle state is standby, that output-enable is high while write-enable is low, and that the address and write data stay constant across a write pulse and the address across a read. It checks that the controller never drives the bus while output-enable is low and that rdValid is a single pulse that follows the end of a read. The exact pulse, hold, access and turnaround lengths are measured only by the bench, together with a behavioural RAM that counts interval and contention violations. The same goes for the correctness of read-back data across random addresses and the ordering of read-then-write turnaround.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WHOLD,
    ST_READ,
    ST_TURN
  } ctrlState_e;

  typedef struct packed {
    logic loadReq;
    logic capture;
    logic driveBus;
  } dpStrobes_t;

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int WR_PULSE_CYC = 6,
  parameter int WR_HOLD_CYC  = 1,
  parameter int RD_ACC_CYC   = 7,
  parameter int TURN_CYC     = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output dpStrobes_t strobes,
  output logic       ceActive,
  output logic       oeActive,
  output logic       weActive
);

  localparam int MAX_A   = (WR_PULSE_CYC > WR_HOLD_CYC) ? WR_PULSE_CYC : WR_HOLD_CYC;
  localparam int MAX_B   = (RD_ACC_CYC > TURN_CYC) ? RD_ACC_CYC : TURN_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrlState_e state;
  logic [CNT_W-1:0] cnt;
  logic cntDone;

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (reqWrite) begin
              state <= ST_WRITE;
              cnt   <= CNT_W'(WR_PULSE_CYC - 1);
            end else begin
              state <= ST_READ;
              cnt   <= CNT_W'(RD_ACC_CYC - 1);
            end
          end
        end
        ST_WRITE: begin
          if (cntDone) begin
            state <= ST_WHOLD;
            cnt   <= CNT_W'(WR_HOLD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_WHOLD: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_READ: begin
          if (cntDone) begin
            state <= ST_TURN;
            cnt   <= CNT_W'(TURN_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TURN: begin
          if (cntDone) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady         = (state == ST_IDLE);
    strobes.loadReq  = (state == ST_IDLE) && reqValid;
    strobes.capture  = (state == ST_READ) && cntDone;
    strobes.driveBus = (state == ST_WRITE) || (state == ST_WHOLD);
    ceActive         = (state == ST_WRITE) || (state == ST_WHOLD) || (state == ST_READ);
    weActive         = (state == ST_WRITE);
    oeActive         = (state == ST_READ);
  end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strobes.loadReq) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
      end
      if (strobes.capture) rdData <= memDqIn;
      rdValid <= strobes.capture;
    end
  end

  assign memDqOe = strobes.driveBus;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int DATA_W       = 8,
  parameter int WR_PULSE_CYC = 6,
  parameter int WR_HOLD_CYC  = 1,
  parameter int RD_ACC_CYC   = 7,
  parameter int TURN_CYC     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memCe,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  dpStrobes_t strobes;
  logic ceActive, oeActive, weActive;

  asram_ctrl_fsm #(
    .WR_PULSE_CYC(WR_PULSE_CYC),
    .WR_HOLD_CYC (WR_HOLD_CYC),
    .RD_ACC_CYC  (RD_ACC_CYC),
    .TURN_CYC    (TURN_CYC)
  ) i_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .strobes  (strobes),
    .ceActive (ceActive),
    .oeActive (oeActive),
    .weActive (weActive)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memDqIn  (memDqIn),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  assign memCeN = ~ceActive;
  assign memCe  = ceActive;
  assign memOeN = ~oeActive;
  assign memWeN = ~weActive;

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memCe,
  input logic              memOeN,
  input logic              memWeN,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  // R2: idle means standby
  a_r2_idle_standby: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && !memCe && memWeN && memOeN && !memDqOe));

  // R3: output enable stays inactive during the write pulse
  a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  // R3: address and data steady across the write pulse
  a_r3_write_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> ($stable(memAddr) && $stable(memDqOut)));

  // R5: no bus drive while the RAM may be driving it
  a_r5_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && !memCeN && memCe));

  // R6: address steady across a read
  a_r6_read_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && $past(!memOeN)) |-> $stable(memAddr));

  // R7: read-valid is a single-cycle pulse
  a_r7_rdvalid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R7: read-valid follows the end of an access
  a_r7_rdvalid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (memOeN && !$past(memOeN)));

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rdValid  (rdValid),
  .memAddr  (memAddr),
  .memCeN   (memCeN),
  .memCe    (memCe),
  .memOeN   (memOeN),
  .memWeN   (memWeN),
  .memDqOut (memDqOut),
  .memDqOe  (memDqOe)
);

// File: tb/test_asram_ctrl.sv
module test_asram_ctrl;

  localparam int CLK_NS    = 10;
  localparam int WP_CYC    = (60 + CLK_NS - 1) / CLK_NS;  // address valid to end of write
  localparam int HOLD_CYC  = 1;
  localparam int RD_CYC    = (70 + CLK_NS - 1) / CLK_NS;  // access time
  localparam int TURN_CYC  = (25 + CLK_NS - 1) / CLK_NS;  // output-disable time

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rdValid;
  logic [7:0]  rdData;
  logic [18:0] memAddr;
  logic        memCeN, memCe, memOeN, memWeN, memDqOe;
  logic [7:0]  memDqOut;
  logic [7:0]  memDqIn = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  asram_ctrl i_asram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr),
    .memCeN(memCeN), .memCe(memCe), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // Behavioural RAM with interval and contention monitoring
  logic [7:0]  ram [int unsigned];
  int          wCnt = 0, rCnt = 0, sinceOe = 1000, viol = 0;
  logic [18:0] wAddr = '0, rAddr = '0;
  logic [7:0]  wDat = '0;
  logic        sel;

  function automatic logic [7:0] ramRd(input logic [18:0] a);
    return ram.exists(a) ? ram[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    sel = !memCeN && memCe;
    if (memDqOe && sinceOe < TURN_CYC) viol++;
    if (memDqOe && sel && !memOeN) viol++;
    if (sel && !memWeN) begin
      if (wCnt > 0 && (memAddr != wAddr || memDqOut != wDat)) viol++;
      if (!memDqOe || !memOeN) viol++;
      wAddr = memAddr; wDat = memDqOut; wCnt++;
    end else if (wCnt > 0) begin
      if (wCnt < WP_CYC) viol++;
      ram[wAddr] = wDat;
      wCnt = 0;
    end
    if (sel && !memOeN && memWeN) begin
      if (rCnt > 0 && memAddr != rAddr) viol++;
      rAddr = memAddr; rCnt++;
    end else if (rCnt > 0) begin
      if (rCnt < RD_CYC) viol++;
      rCnt = 0;
    end
    if (sel && !memOeN) sinceOe = 0;
    else if (sinceOe < 1000) sinceOe++;
  end

  always @(negedge clk) begin
    if (!memCeN && memCe && !memOeN && memWeN && rCnt >= RD_CYC - 1)
      memDqIn <= ramRd(memAddr);
    else
      memDqIn <= ~ramRd(memAddr);
  end

  // Bench expectations
  logic [7:0] shadow [int unsigned];

  function automatic logic [7:0] expRd(input logic [18:0] a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic standbyChk(input string tag);
    chk(tag, {reqReady, memCeN, memCe, memWeN, memOeN, memDqOe}, 6'b110110);
  endtask

  task automatic runOp(input bit isWr, input logic [18:0] a, input logic [7:0] d);
    int weLow = 0, hold = 0, drv = 0, oeLow = 0, stby = 0, vld = 0;
    logic [7:0] got = '0;
    @(negedge clk);
    for (int i = 0; i < 64 && !reqReady; i++) @(negedge clk);
    reqValid = 1'b1; reqWrite = isWr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 ready low after accept", reqReady, 1'b0);
    for (int i = 0; i < 64 && !reqReady; i++) begin
      if (!memWeN) weLow++;
      if (memWeN && !memCeN && memDqOe) hold++;
      if (memDqOe) drv++;
      if (!memOeN) oeLow++;
      if (rdValid) begin vld++; got = rdData; end
      if (memCeN && !memCe) stby++;
      @(negedge clk);
    end
    standbyChk("R2 standby when ready");
    if (isWr) begin
      shadow[a] = d;
      chk("R3 write pulse cycles", weLow, WP_CYC);
      chk("R4 write hold cycles", hold, HOLD_CYC);
      chk("R5 write drive cycles", drv, WP_CYC + HOLD_CYC);
      chk("R8 no standby gap in write", stby, 0);
    end else begin
      chk("R6 read access cycles", oeLow, RD_CYC);
      chk("R5 no drive in read", drv, 0);
      chk("R7 rdValid pulse count", vld, 1);
      chk("R10 read data", got, expRd(a));
      chk("R8 turnaround cycles", stby, TURN_CYC);
    end
  endtask

  initial begin
    logic [18:0] pool [16];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    standbyChk("R1 standby in reset");
    chk("R1 rdValid in reset", rdValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    standbyChk("R1 standby after reset");
    chk("R1 rdValid after reset", rdValid, 1'b0);

    // Directed corners
    runOp(1'b0, 19'h00123, 8'h00);  // unwritten location
    runOp(1'b1, 19'h00000, 8'hA5);
    runOp(1'b1, 19'h7FFFF, 8'hFF);
    runOp(1'b0, 19'h00000, 8'h00);
    runOp(1'b0, 19'h7FFFF, 8'h00);
    runOp(1'b1, 19'h7FFFF, 8'h00);  // read then write: turnaround
    runOp(1'b0, 19'h7FFFF, 8'h00);
    runOp(1'b1, 19'h2AAAA, 8'h5A);  // overwrite ordering
    runOp(1'b1, 19'h2AAAA, 8'hC3);
    runOp(1'b0, 19'h2AAAA, 8'h00);

    // Constrained random mix over a pool of addresses
    for (int i = 0; i < 16; i++) pool[i] = 19'($urandom);
    pool[0] = 19'h00000;
    pool[1] = 19'h7FFFF;
    for (int n = 0; n < 200; n++) begin
      logic [18:0] a;
      a = pool[$urandom_range(15, 0)];
      runOp($urandom_range(1, 0) == 1, a, 8'($urandom));
    end
    for (int i = 0; i < 16; i++) runOp(1'b0, pool[i], 8'h00);

    repeat (5) @(negedge clk);
    chk("R3 R6 R8 model violations", viol, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule